// File: doc/BRIEF.md
# Banked UART Register Access Front End

This block sits between a host register bus and the rest of a 16550-style UART that has enhanced flow-control features. Each access carries a 3-bit offset and a read or write strobe. The block sends the access to one of its own configuration registers or to a pass-through port that serves the operational registers downstream. The FIFOs, the baud generator and the serializer live behind that port.

The stored line-control value selects which register bank the offsets reach. The block has three views. The operational view is the normal one. Configuration view A opens whenever the top line-control bit is set. Configuration view B opens only for one key value of the line-control register. The threshold register for automatic RTS is a further sub-view. It appears only after the host has set the sub-mode bit in the modem-control register and the enhanced-enable bit in the feature register, and those two bits live in different banks.

The block holds four registers: line control, modem control, feature control and threshold control. It drives their contents, together with the decoded flow-control fields, to the rest of the UART.

Top module: `uart_bank_cfg`

## Requirements
- R1: After reset, the line, modem, feature and threshold registers are all 0x00. The bank mode is operational (code 0) and every flow-control output is 0.
- R2: Offset 3 reads and writes the line-control register in every bank mode.
- R3: The bank mode is decoded from the stored line-control value and shown on `cfg_mode`. A value of exactly 0xBF gives view B (code 2). Any other value with bit 7 set gives view A (code 1). A value with bit 7 clear gives operational (code 0).
- R4: Offset 4 reads and writes the modem-control register in operational mode and in view A.
- R5: Offset 2 reaches the feature register only in view B. Its bit 7 drives `auto_cts_en`, bit 6 drives `auto_rts_en` and bit 4 drives `enh_en`. Outside view B, a write to offset 2 leaves the feature register unchanged.
- R6: A write to modem-control bit 6 (the threshold sub-mode bit) takes effect only while feature bit 4 is 1. Otherwise that bit keeps its old value and the other seven bits are written.
- R7: Offset 6 reaches the threshold register, in any bank mode, only while modem bit 6 and feature bit 4 are both 1. Bits 7:4 drive `rts_resume_lvl` and bits 3:0 drive `rts_halt_lvl`. Otherwise a write to offset 6 leaves the threshold register unchanged.
- R8: In operational mode and in view A, an access to an offset the block does not own asserts `op_wr_en` or `op_rd_en` in the same cycle. It drives `op_addr` and `op_wdata` from the bus, and `rdata` returns `op_rdata`.
- R9: In view B, an access to an offset the block does not own is unmapped. No pass-through strobe is asserted, a read returns 0x00, and a write changes no register.
- R10: Read data is valid in the same cycle as `rd_en`. While `rd_en` is low, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, same cycle |
| op_wr_en | output | 1 | Pass-through write strobe |
| op_rd_en | output | 1 | Pass-through read strobe |
| op_addr | output | 3 | Pass-through offset |
| op_wdata | output | 8 | Pass-through write data |
| op_rdata | input | 8 | Pass-through read data |
| cfg_mode | output | 2 | Bank mode: 0 operational, 1 view A, 2 view B |
| line_ctrl | output | 8 | Line-control register contents |
| modem_ctrl | output | 8 | Modem-control register contents |
| feat_ctrl | output | 8 | Feature register contents |
| auto_cts_en | output | 1 | Automatic CTS enable |
| auto_rts_en | output | 1 | Automatic RTS enable |
| enh_en | output | 1 | Enhanced-function enable |
| rts_resume_lvl | output | 4 | RTS resume threshold |
| rts_halt_lvl | output | 4 | RTS halt threshold |

## Verification
The bench builds the block with its default parameters: 8-bit data, 3-bit offsets, owned offsets 3, 4, 2 and 6, and view-B key 0xBF. With these values every offset and every bank mode can be reached with a few writes. The bench walks the full unlock sequence for the threshold register across both configuration views. It also covers the corners: a line-control value with bit 7 set that is one away from the key, a sub-mode write that is refused, and a threshold register that hides again once enhanced-enable is cleared.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  typedef enum logic [1:0] {
    MODE_OP    = 2'd0,
    MODE_CFG_A = 2'd1,
    MODE_CFG_B = 2'd2
  } bank_mode_e;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_LCR  = 3'd1,
    TGT_MCR  = 3'd2,
    TGT_EFR  = 3'd3,
    TGT_TCR  = 3'd4,
    TGT_PASS = 3'd5
  } bank_tgt_e;

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OFF_LCR = ADDR_W'(3),
  parameter logic [ADDR_W-1:0] OFF_MCR = ADDR_W'(4),
  parameter logic [ADDR_W-1:0] OFF_EFR = ADDR_W'(2),
  parameter logic [ADDR_W-1:0] OFF_TCR = ADDR_W'(6),
  parameter logic [DATA_W-1:0] KEY_B   = DATA_W'(8'hBF)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] lcr_q,
  input  logic              sub_bit,
  input  logic              enh_bit,
  output bank_mode_e        mode,
  output bank_tgt_e         tgt
);

  logic sub_on;

  // bank view from the stored line-control value
  always_comb begin
    if (lcr_q == KEY_B) begin
      mode = MODE_CFG_B;
    end else if (lcr_q[DATA_W-1]) begin
      mode = MODE_CFG_A;
    end else begin
      mode = MODE_OP;
    end
  end

  assign sub_on = sub_bit & enh_bit;

  // target select, in priority order
  always_comb begin
    if (addr == OFF_LCR) begin
      tgt = TGT_LCR;
    end else if (sub_on && (addr == OFF_TCR)) begin
      tgt = TGT_TCR;
    end else if ((mode != MODE_CFG_B) && (addr == OFF_MCR)) begin
      tgt = TGT_MCR;
    end else if ((mode == MODE_CFG_B) && (addr == OFF_EFR)) begin
      tgt = TGT_EFR;
    end else if (mode == MODE_CFG_B) begin
      tgt = TGT_NONE;
    end else begin
      tgt = TGT_PASS;
    end
  end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MCR_SUB_BIT = 6,
  parameter int EFR_ENH_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  bank_tgt_e         tgt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lcr_q,
  output logic [DATA_W-1:0] mcr_q,
  output logic [DATA_W-1:0] efr_q,
  output logic [DATA_W-1:0] tcr_q
);

  localparam int NREG = 4;
  localparam int IDX_LCR = 0;
  localparam int IDX_MCR = 1;
  localparam int IDX_EFR = 2;
  localparam int IDX_TCR = 3;

  logic [NREG-1:0]  reg_en;
  logic [DATA_W-1:0] reg_d [NREG];
  logic [DATA_W-1:0] reg_q [NREG];
  logic [DATA_W-1:0] mcr_next;

  // clock enables, one per register
  assign reg_en[IDX_LCR] = wr_en && (tgt == TGT_LCR);
  assign reg_en[IDX_MCR] = wr_en && (tgt == TGT_MCR);
  assign reg_en[IDX_EFR] = wr_en && (tgt == TGT_EFR);
  assign reg_en[IDX_TCR] = wr_en && (tgt == TGT_TCR);

  // the sub-mode bit is held unless enhanced-enable is set
  always_comb begin
    mcr_next = wdata;
    if (!efr_q[EFR_ENH_BIT]) begin
      mcr_next[MCR_SUB_BIT] = mcr_q[MCR_SUB_BIT];
    end
  end

  // next-state values
  always_comb begin
    reg_d[IDX_LCR] = wdata;
    reg_d[IDX_MCR] = mcr_next;
    reg_d[IDX_EFR] = wdata;
    reg_d[IDX_TCR] = wdata;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else if (reg_en[g]) begin
        reg_q[g] <= reg_d[g];
      end
    end
  end

  assign lcr_q = reg_q[IDX_LCR];
  assign mcr_q = reg_q[IDX_MCR];
  assign efr_q = reg_q[IDX_EFR];
  assign tcr_q = reg_q[IDX_TCR];

endmodule

// File: rtl/uart_bank_rdmux.sv
module uart_bank_rdmux
  import uart_bank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              rd_en,
  input  bank_tgt_e         tgt,
  input  logic [DATA_W-1:0] lcr_q,
  input  logic [DATA_W-1:0] mcr_q,
  input  logic [DATA_W-1:0] efr_q,
  input  logic [DATA_W-1:0] tcr_q,
  input  logic [DATA_W-1:0] op_rdata,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (tgt)
        TGT_LCR:  rdata = lcr_q;
        TGT_MCR:  rdata = mcr_q;
        TGT_EFR:  rdata = efr_q;
        TGT_TCR:  rdata = tcr_q;
        TGT_PASS: rdata = op_rdata;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_bank_cfg.sv
module uart_bank_cfg
  import uart_bank_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int OFF_LCR     = 3,
  parameter int OFF_MCR     = 4,
  parameter int OFF_EFR     = 2,
  parameter int OFF_TCR     = 6,
  parameter int KEY_B       = 8'hBF,
  parameter int MCR_SUB_BIT = 6,
  parameter int EFR_ENH_BIT = 4,
  parameter int EFR_CTS_BIT = 7,
  parameter int EFR_RTS_BIT = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   op_wr_en,
  output logic                   op_rd_en,
  output logic [ADDR_W-1:0]      op_addr,
  output logic [DATA_W-1:0]      op_wdata,
  input  logic [DATA_W-1:0]      op_rdata,
  output logic [1:0]             cfg_mode,
  output logic [DATA_W-1:0]      line_ctrl,
  output logic [DATA_W-1:0]      modem_ctrl,
  output logic [DATA_W-1:0]      feat_ctrl,
  output logic                   auto_cts_en,
  output logic                   auto_rts_en,
  output logic                   enh_en,
  output logic [DATA_W/2-1:0]    rts_resume_lvl,
  output logic [DATA_W/2-1:0]    rts_halt_lvl
);

  localparam int LVL_W = DATA_W / 2;

  bank_mode_e        mode_w;
  bank_tgt_e         tgt_w;
  logic [DATA_W-1:0] lcr_q;
  logic [DATA_W-1:0] mcr_q;
  logic [DATA_W-1:0] efr_q;
  logic [DATA_W-1:0] tcr_q;

  uart_bank_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .OFF_LCR (ADDR_W'(OFF_LCR)),
    .OFF_MCR (ADDR_W'(OFF_MCR)),
    .OFF_EFR (ADDR_W'(OFF_EFR)),
    .OFF_TCR (ADDR_W'(OFF_TCR)),
    .KEY_B   (DATA_W'(KEY_B))
  ) u_decode (
    .addr    (addr),
    .lcr_q   (lcr_q),
    .sub_bit (mcr_q[MCR_SUB_BIT]),
    .enh_bit (efr_q[EFR_ENH_BIT]),
    .mode    (mode_w),
    .tgt     (tgt_w)
  );

  uart_bank_regs #(
    .DATA_W      (DATA_W),
    .MCR_SUB_BIT (MCR_SUB_BIT),
    .EFR_ENH_BIT (EFR_ENH_BIT)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .tgt   (tgt_w),
    .wdata (wdata),
    .lcr_q (lcr_q),
    .mcr_q (mcr_q),
    .efr_q (efr_q),
    .tcr_q (tcr_q)
  );

  uart_bank_rdmux #(
    .DATA_W (DATA_W)
  ) u_rdmux (
    .rd_en    (rd_en),
    .tgt      (tgt_w),
    .lcr_q    (lcr_q),
    .mcr_q    (mcr_q),
    .efr_q    (efr_q),
    .tcr_q    (tcr_q),
    .op_rdata (op_rdata),
    .rdata    (rdata)
  );

  // pass-through port to the operational registers
  assign op_wr_en = wr_en && (tgt_w == TGT_PASS);
  assign op_rd_en = rd_en && (tgt_w == TGT_PASS);
  assign op_addr  = addr;
  assign op_wdata = wdata;

  // exported state
  assign cfg_mode       = mode_w;
  assign line_ctrl      = lcr_q;
  assign modem_ctrl     = mcr_q;
  assign feat_ctrl      = efr_q;
  assign auto_cts_en    = efr_q[EFR_CTS_BIT];
  assign auto_rts_en    = efr_q[EFR_RTS_BIT];
  assign enh_en         = efr_q[EFR_ENH_BIT];
  assign rts_resume_lvl = tcr_q[DATA_W-1:LVL_W];
  assign rts_halt_lvl   = tcr_q[LVL_W-1:0];

endmodule

// File: rtl/uart_bank_chk.sv
module uart_bank_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              op_wr_en,
  input logic              op_rd_en,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] op_wdata,
  input logic [1:0]        cfg_mode,
  input logic [DATA_W-1:0] line_ctrl,
  input logic [DATA_W-1:0] modem_ctrl,
  input logic [DATA_W-1:0] feat_ctrl
);

  // R2: line control loads from offset 3 in any mode
  a_r2_lcr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(3)) |=> line_ctrl == $past(wdata));

  // R3: key value selects view B
  a_r3_key_view_b: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ctrl == DATA_W'(8'hBF)) |-> cfg_mode == 2'd2);

  // R5: feature register only writable in view B
  a_r5_efr_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_mode != 2'd2) |=> feat_ctrl == $past(feat_ctrl));

  // R6: sub-mode bit locked while enhanced-enable is clear
  a_r6_sub_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !feat_ctrl[4]) |=> modem_ctrl[6] == $past(modem_ctrl[6]));

  // R8: pass-through carries bus address and data
  a_r8_pass_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr_en || op_rd_en) |-> (op_addr == addr && op_wdata == wdata));

  // R9: no pass-through traffic in view B
  a_r9_no_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2) |-> !(op_wr_en || op_rd_en));

  // R10: idle read bus is zero
  a_r10_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);

endmodule

bind uart_bank_cfg uart_bank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .op_wr_en   (op_wr_en),
  .op_rd_en   (op_rd_en),
  .op_addr    (op_addr),
  .op_wdata   (op_wdata),
  .cfg_mode   (cfg_mode),
  .line_ctrl  (line_ctrl),
  .modem_ctrl (modem_ctrl),
  .feat_ctrl  (feat_ctrl)
);

// File: tb/uart_bank_cfg_tb.sv
`timescale 1ns/1ps
module uart_bank_cfg_tb;

  localparam int CLK_HALF = 10;

  logic       clk;
  logic       rst_n;
  logic [2:0] addr;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       op_wr_en;
  logic       op_rd_en;
  logic [2:0] op_addr;
  logic [7:0] op_wdata;
  logic [7:0] op_rdata;
  logic [1:0] cfg_mode;
  logic [7:0] line_ctrl;
  logic [7:0] modem_ctrl;
  logic [7:0] feat_ctrl;
  logic       auto_cts_en;
  logic       auto_rts_en;
  logic       enh_en;
  logic [3:0] rts_resume_lvl;
  logic [3:0] rts_halt_lvl;

  int n_chk;
  int n_bad;
  logic       seen_op_wr;
  logic       seen_op_rd;
  logic [2:0] seen_op_addr;
  logic [7:0] seen_op_wdata;

  // simple model of the downstream operational registers
  assign op_rdata = 8'h50 | {5'b0, op_addr};

  uart_bank_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .op_wr_en(op_wr_en), .op_rd_en(op_rd_en),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_rdata(op_rdata),
    .cfg_mode(cfg_mode), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl),
    .feat_ctrl(feat_ctrl), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
    .enh_en(enh_en), .rts_resume_lvl(rts_resume_lvl), .rts_halt_lvl(rts_halt_lvl)
  );

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #2;
    seen_op_wr = op_wr_en; seen_op_addr = op_addr; seen_op_wdata = op_wdata;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2;
    d = rdata; seen_op_rd = op_rd_en;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 line_ctrl", line_ctrl, 8'h00);
    chk("R1 modem_ctrl", modem_ctrl, 8'h00);
    chk("R1 feat_ctrl", feat_ctrl, 8'h00);
    chk("R1 thresholds", {rts_resume_lvl, rts_halt_lvl}, 8'h00);
    chk("R1 mode", {6'b0, cfg_mode}, 8'h00);
    chk("R1 flow bits", {5'b0, auto_cts_en, auto_rts_en, enh_en}, 8'h00);
    bus_rd(3'd3, v);
    chk("R1 R2 lcr read", v, 8'h00);
    chk("R10 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_modes();
    logic [7:0] v;
    bus_wr(3'd3, 8'h03);
    chk("R3 op mode", {6'b0, cfg_mode}, 8'h00);
    bus_wr(3'd3, 8'h80);
    chk("R3 view A", {6'b0, cfg_mode}, 8'h01);
    bus_wr(3'd3, 8'hBE);
    chk("R3 near key is A", {6'b0, cfg_mode}, 8'h01);
    bus_wr(3'd3, 8'hBF);
    chk("R3 view B", {6'b0, cfg_mode}, 8'h02);
    bus_rd(3'd3, v);
    chk("R2 lcr read in B", v, 8'hBF);
  endtask

  task automatic t_pass();
    logic [7:0] v;
    bus_wr(3'd3, 8'h03);
    bus_rd(3'd0, v);
    chk("R8 pass read data", v, 8'h50);
    chk("R8 pass read strobe", {7'b0, seen_op_rd}, 8'h01);
    bus_wr(3'd1, 8'h5A);
    chk("R8 pass wr strobe", {7'b0, seen_op_wr}, 8'h01);
    chk("R8 pass wr addr", {5'b0, seen_op_addr}, 8'h01);
    chk("R8 pass wr data", seen_op_wdata, 8'h5A);
    bus_wr(3'd2, 8'hD0);
    chk("R5 offset 2 outside B passes", {7'b0, seen_op_wr}, 8'h01);
    chk("R5 efr untouched outside B", feat_ctrl, 8'h00);
    bus_wr(3'd6, 8'h77);
    chk("R7 offset 6 hidden passes", {7'b0, seen_op_wr}, 8'h01);
    chk("R7 tcr untouched while hidden", {rts_resume_lvl, rts_halt_lvl}, 8'h00);
  endtask

  task automatic t_mcr_lock();
    logic [7:0] v;
    bus_wr(3'd3, 8'h00);
    bus_wr(3'd4, 8'h5F);
    bus_rd(3'd4, v);
    chk("R4 R6 mcr bit6 refused", v, 8'h1F);
  endtask

  task automatic t_view_b();
    logic [7:0] v;
    bus_wr(3'd3, 8'hBF);
    bus_wr(3'd2, 8'hD0);
    chk("R5 cts/rts/enh", {5'b0, auto_cts_en, auto_rts_en, enh_en}, 8'h07);
    bus_rd(3'd2, v);
    chk("R5 efr read", v, 8'hD0);
    bus_rd(3'd0, v);
    chk("R9 unmapped read", v, 8'h00);
    chk("R9 no pass read", {7'b0, seen_op_rd}, 8'h00);
    bus_wr(3'd4, 8'hFF);
    chk("R9 no pass write", {7'b0, seen_op_wr}, 8'h00);
    chk("R9 mcr untouched", modem_ctrl, 8'h1F);
  endtask

  task automatic t_tcr();
    logic [7:0] v;
    bus_wr(3'd3, 8'h80);
    bus_wr(3'd4, 8'h40);
    bus_rd(3'd4, v);
    chk("R4 R6 mcr bit6 accepted", v, 8'h40);
    bus_wr(3'd6, 8'hA3);
    chk("R7 tcr write no pass", {7'b0, seen_op_wr}, 8'h00);
    chk("R7 thresholds", {rts_resume_lvl, rts_halt_lvl}, 8'hA3);
    bus_rd(3'd6, v);
    chk("R7 tcr read", v, 8'hA3);
    bus_wr(3'd3, 8'hBF);
    bus_rd(3'd6, v);
    chk("R7 tcr read in B", v, 8'hA3);
    bus_wr(3'd2, 8'hC0);
    bus_wr(3'd3, 8'h80);
    bus_rd(3'd6, v);
    chk("R7 hidden again passes", v, 8'h56);
    bus_wr(3'd6, 8'h11);
    chk("R7 tcr kept", {rts_resume_lvl, rts_halt_lvl}, 8'hA3);
    bus_wr(3'd4, 8'h00);
    chk("R6 bit6 held with enh clear", modem_ctrl, 8'h40);
    @(negedge clk);
    chk("R10 rdata idle", rdata, 8'h00);
  endtask

  initial begin
    #(2 * CLK_HALF * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    seen_op_wr = 1'b0; seen_op_rd = 1'b0;
    seen_op_addr = '0; seen_op_wdata = '0;
    addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_modes();
    t_pass();
    t_mcr_lock();
    t_view_b();
    t_tcr();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule